// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Indexed Register Access

The block collects a parameterised number of system interrupt sources (64 by default), brings each one into the clock domain through a synchronizer, and detects either an edge or a level on it. The detection rule and the active sense are chosen per source. A detected event sets that source's status latch. Each source also has an enable bit and an 8-bit channel number. The block drives one host interrupt line, and a prioritized-index register reports the pending, enabled source that wins the priority selection.

Software reaches the block over a 32-bit register bus. Writes take effect on the next clock edge, and reads are returned in the same cycle. A handler can set or clear one source's enable, or clear one source's status, by writing the source number to a dedicated index register, with no read-modify-write. Bulk write-one-to-clear words and per-bit configuration words cover initialisation. One read of the prioritized-index register gives the source to service, plus a flag that marks the read as spurious when nothing is pending.

Top module: `irqc_top`

## Requirements
- R1: After reset, all status, enable, polarity, type, channel, global-enable, host-enable and control bits are 0. `host_irq` is low, and the prioritized-index register (byte address 0x80) reads 0x8000_0000.
- R2: Every source input passes a two-flop synchronizer. An input change made between clock edges shows in the status bit after the third rising edge, and not earlier.
- R3: The type bit selects the detection rule, with 1 meaning edge. An edge source with polarity 1 latches its status on a 0-to-1 transition. An edge source with polarity 0 latches on a 1-to-0 transition. The opposite transition sets nothing.
- R4: The type bit set to 0 selects level. A level source sets its status on every cycle in which its synchronized input equals its polarity bit (1 means high, 0 means low). While that level persists, a clear does not leave the status at 0.
- R5: Writing source number s in bits 9:0 to address 0x24 clears status bit s. If a detection event for s occurs in the same cycle, the event wins.
- R6: Writing s to 0x28 sets enable bit s, and writing s to 0x2C clears it. A number of NUM_SRC or more written to either address changes no enable.
- R7: Writing host number h to 0x34 sets host-enable bit h, and writing h to 0x38 clears it. Numbers of NUM_HOST or more are ignored. The word at 0x1500 reads and writes all host-enable bits directly, with bit h belonging to host h.
- R8: Bit b of the word at 0x280+4n is the status of source 32n+b, and writing 1 to a bit clears that status. Bit b of the word at 0x380+4n reads as the enable of source 32n+b, and writing 1 to a bit clears that enable.
- R9: Byte k of the word at 0x400+4n holds the channel of source 4n+k. Bit b of the word at 0xD00+4n is the polarity of source 32n+b, and bit b of the word at 0xD80+4n is its type. All of these words read back what was written.
- R10: Among sources that are both pending and enabled, the lowest channel number wins, and a tie goes to the lowest source number. The winner appears in bits 9:0 of the word at 0x80, one cycle after the state that produced it.
- R11: When no source is both pending and enabled, the word at 0x80 reads 0x8000_0000 (bit 31 set, bits 9:0 zero). Pending sources whose enable is clear never win.
- R12: `host_irq` is high exactly when bit 0 of the word at 0x10 is 1, host-enable bit 0 is 1, and at least one source is both pending and enabled.
- R13: The control words at 0x04 and 0x0C keep and return the value written. Writing 0 to them selects the only mode the block has, and no value written to them changes the interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw system interrupt inputs |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| host_irq | output | 1 | Host interrupt request |

## Verification
A behavioural model in the bench runs alongside the design and is compared against it on every clock, including on bus read data for whatever address is being presented. Stimulus covers rising and falling edges, both opposite transitions, and active-high and active-low levels. Comparing these patterns separates edge detection from level detection and shows whether polarity is honoured. Index clears are timed to land in the same cycle as a new edge, and also applied while a level persists, so both collision rules are exercised. Channel assignments include a tie on the lowest channel and disabled pending sources, which separate the channel ordering, the source-number tie-break and the enable gating.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int IDX_W = 10;
   localparam int CH_W  = 8;

   localparam int A_CTRL      = 'h004;
   localparam int A_HCTRL     = 'h00C;
   localparam int A_GLB       = 'h010;
   localparam int A_STAT_ICLR = 'h024;
   localparam int A_EN_ISET   = 'h028;
   localparam int A_EN_ICLR   = 'h02C;
   localparam int A_HEN_ISET  = 'h034;
   localparam int A_HEN_ICLR  = 'h038;
   localparam int A_PRI       = 'h080;
   localparam int A_STAT_W    = 'h280;
   localparam int A_ENCLR_W   = 'h380;
   localparam int A_MAP_W     = 'h400;
   localparam int A_POL_W     = 'hD00;
   localparam int A_TYP_W     = 'hD80;
   localparam int A_HEN_W     = 'h1500;

   typedef struct packed {
      logic             none;
      logic [IDX_W-1:0] idx;
   } pick_t;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
   parameter int NUM_SRC     = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [NUM_SRC-1:0] pol,
   input  logic [NUM_SRC-1:0] typ,
   output logic [NUM_SRC-1:0] hit
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [NUM_SRC-1:0] stg_q [SYNC_STAGES];
   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC_STAGES; k++) stg_q[k] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= src_in;
         for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
         prev_q <= stg_q[LAST];
      end
   end

   assign cur = stg_q[LAST];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic rise, fall;
      assign rise   = cur[i] & ~prev_q[i];
      assign fall   = ~cur[i] & prev_q[i];
      assign hit[i] = typ[i] ? (pol[i] ? rise : fall) : (cur[i] == pol[i]);
   end

   AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(typ) && $stable(pol)) |-> ((hit & typ & $past(hit)) == '0)); // R3
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SRC-1:0]      pend,
   input  logic [NUM_SRC*CH_W-1:0] chan,
   output pick_t                   pick_o
);
   logic             found;
   logic [CH_W-1:0]  best_ch;
   logic [IDX_W-1:0] best;
   pick_t            pick_q;
   logic [NUM_SRC-1:0] pend_d;

   always_comb begin
      found   = 1'b0;
      best_ch = '1;
      best    = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend[i] && (!found || chan[i*CH_W +: CH_W] < best_ch)) begin
            found   = 1'b1;
            best_ch = chan[i*CH_W +: CH_W];
            best    = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pick_q <= '{none: 1'b1, idx: '0};
         pend_d <= '0;
      end else begin
         pick_q.none <= !found;
         pick_q.idx  <= best;
         pend_d      <= pend;
      end
   end

   assign pick_o = pick_q;

   AST_PICK_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_q.none |-> |(pend_d & (NUM_SRC'(1) << pick_q.idx))); // R10
   AST_NONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pick_q.none |-> (pend_d == '0 && pick_q.idx == '0)); // R11
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int NUM_HOST = 2,
   parameter int ADDR_W   = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_wen,
   input  logic [31:0]             bus_wdata,
   input  logic [NUM_SRC-1:0]      hit,
   input  pick_t                   pick,
   output logic [NUM_SRC-1:0]      st_o,
   output logic [NUM_SRC-1:0]      en_o,
   output logic [NUM_SRC-1:0]      pol_o,
   output logic [NUM_SRC-1:0]      typ_o,
   output logic [NUM_SRC*CH_W-1:0] chan_o,
   output logic                    glb_o,
   output logic [NUM_HOST-1:0]     hen_o,
   output logic [31:0]             bus_rdata
);
   localparam int NWORD = NUM_SRC / 32;
   localparam int NMAP  = NUM_SRC / 4;

   logic [NUM_SRC-1:0]      st_q, en_q, pol_q, typ_q;
   logic [NUM_SRC*CH_W-1:0] map_q;
   logic                    glb_q;
   logic [NUM_HOST-1:0]     hen_q;
   logic [31:0]             ctrl_q, hctrl_q;

   logic [IDX_W-1:0]   num;
   logic               num_ok, hnum_ok;
   logic [NUM_SRC-1:0] src_oh;
   logic [NUM_HOST-1:0] host_oh;

   assign num     = bus_wdata[IDX_W-1:0];
   assign num_ok  = {1'b0, num} < (IDX_W+1)'(NUM_SRC);
   assign hnum_ok = {1'b0, num} < (IDX_W+1)'(NUM_HOST);
   assign src_oh  = num_ok  ? (NUM_SRC'(1)  << num) : '0;
   assign host_oh = hnum_ok ? (NUM_HOST'(1) << num) : '0;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int base);
      return a == ADDR_W'(base);
   endfunction

   logic wr_ctrl, wr_hctrl, wr_glb, wr_st_iclr, wr_en_iset, wr_en_iclr;
   logic wr_hen_iset, wr_hen_iclr, wr_hen_w;
   assign wr_ctrl     = bus_wen && at(bus_addr, A_CTRL);
   assign wr_hctrl    = bus_wen && at(bus_addr, A_HCTRL);
   assign wr_glb      = bus_wen && at(bus_addr, A_GLB);
   assign wr_st_iclr  = bus_wen && at(bus_addr, A_STAT_ICLR);
   assign wr_en_iset  = bus_wen && at(bus_addr, A_EN_ISET);
   assign wr_en_iclr  = bus_wen && at(bus_addr, A_EN_ICLR);
   assign wr_hen_iset = bus_wen && at(bus_addr, A_HEN_ISET);
   assign wr_hen_iclr = bus_wen && at(bus_addr, A_HEN_ICLR);
   assign wr_hen_w    = bus_wen && at(bus_addr, A_HEN_W);

   logic [NWORD-1:0] stw_wr, enw_wr, polw_wr, typw_wr;
   logic [NMAP-1:0]  map_wr;

   for (genvar w = 0; w < NWORD; w++) begin : g_bit_words
      assign stw_wr[w]  = bus_wen && at(bus_addr, A_STAT_W  + 4*w);
      assign enw_wr[w]  = bus_wen && at(bus_addr, A_ENCLR_W + 4*w);
      assign polw_wr[w] = bus_wen && at(bus_addr, A_POL_W   + 4*w);
      assign typw_wr[w] = bus_wen && at(bus_addr, A_TYP_W   + 4*w);
   end

   for (genvar m = 0; m < NMAP; m++) begin : g_map_words
      assign map_wr[m] = bus_wen && at(bus_addr, A_MAP_W + 4*m);
   end

   logic [NUM_SRC-1:0] st_clr, en_clr, en_set;

   always_comb begin
      st_clr = wr_st_iclr ? src_oh : '0;
      en_clr = wr_en_iclr ? src_oh : '0;
      en_set = wr_en_iset ? src_oh : '0;
      for (int w = 0; w < NWORD; w++) begin
         if (stw_wr[w]) st_clr[w*32 +: 32] = bus_wdata;
         if (enw_wr[w]) en_clr[w*32 +: 32] = bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         en_q    <= '0;
         pol_q   <= '0;
         typ_q   <= '0;
         map_q   <= '0;
         glb_q   <= 1'b0;
         hen_q   <= '0;
         ctrl_q  <= '0;
         hctrl_q <= '0;
      end else begin
         st_q <= (st_q & ~st_clr) | hit;
         en_q <= (en_q & ~en_clr) | en_set;
         for (int w = 0; w < NWORD; w++) begin
            if (polw_wr[w]) pol_q[w*32 +: 32] <= bus_wdata;
            if (typw_wr[w]) typ_q[w*32 +: 32] <= bus_wdata;
         end
         for (int m = 0; m < NMAP; m++) begin
            if (map_wr[m]) map_q[m*32 +: 32] <= bus_wdata;
         end
         if (wr_glb)   glb_q   <= bus_wdata[0];
         if (wr_ctrl)  ctrl_q  <= bus_wdata;
         if (wr_hctrl) hctrl_q <= bus_wdata;
         if (wr_hen_w)         hen_q <= bus_wdata[NUM_HOST-1:0];
         else if (wr_hen_iset) hen_q <= hen_q | host_oh;
         else if (wr_hen_iclr) hen_q <= hen_q & ~host_oh;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (at(bus_addr, A_CTRL))  bus_rdata = ctrl_q;
      if (at(bus_addr, A_HCTRL)) bus_rdata = hctrl_q;
      if (at(bus_addr, A_GLB))   bus_rdata = {31'b0, glb_q};
      if (at(bus_addr, A_PRI))   bus_rdata = {pick.none, {(31-IDX_W){1'b0}}, pick.idx};
      if (at(bus_addr, A_HEN_W)) bus_rdata = {{(32-NUM_HOST){1'b0}}, hen_q};
      for (int w = 0; w < NWORD; w++) begin
         if (at(bus_addr, A_STAT_W  + 4*w)) bus_rdata = st_q[w*32 +: 32];
         if (at(bus_addr, A_ENCLR_W + 4*w)) bus_rdata = en_q[w*32 +: 32];
         if (at(bus_addr, A_POL_W   + 4*w)) bus_rdata = pol_q[w*32 +: 32];
         if (at(bus_addr, A_TYP_W   + 4*w)) bus_rdata = typ_q[w*32 +: 32];
      end
      for (int m = 0; m < NMAP; m++) begin
         if (at(bus_addr, A_MAP_W + 4*m)) bus_rdata = map_q[m*32 +: 32];
      end
   end

   assign st_o   = st_q;
   assign en_o   = en_q;
   assign pol_o  = pol_q;
   assign typ_o  = typ_q;
   assign chan_o = map_q;
   assign glb_o  = glb_q;
   assign hen_o  = hen_q;

   AST_IDX_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_st_iclr && !(|(hit & src_oh))) |=> ((st_q & $past(src_oh)) == '0)); // R5
   AST_IDX_SET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_iset |=> ((en_q & $past(src_oh)) == $past(src_oh))); // R6
   AST_IDX_CLEAR_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_iclr |=> ((en_q & $past(src_oh)) == '0)); // R6
   AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en_iset || wr_en_iclr) && !num_ok) |=> $stable(en_q)); // R6
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_SRC     = 64,
   parameter int NUM_HOST    = 2,
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wen,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               host_irq
);
   if (NUM_SRC % 32 != 0 || NUM_SRC > (1 << IDX_W)) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 and fit the index field");
   end
   if (NUM_HOST < 1 || NUM_HOST > 31) begin : g_bad_host
      $error("NUM_HOST must lie between 1 and 31");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) <= A_HEN_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_SRC-1:0]      hit, st, en, pol, typ;
   logic [NUM_SRC*CH_W-1:0] chan;
   logic                    glb;
   logic [NUM_HOST-1:0]     hen;
   pick_t                   pick;

   irqc_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .pol(pol), .typ(typ), .hit(hit)
   );

   irqc_regs #(.NUM_SRC(NUM_SRC), .NUM_HOST(NUM_HOST), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .hit(hit), .pick(pick), .st_o(st), .en_o(en),
      .pol_o(pol), .typ_o(typ), .chan_o(chan), .glb_o(glb), .hen_o(hen),
      .bus_rdata(bus_rdata)
   );

   irqc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
      .clk(clk), .rst_n(rst_n), .pend(st & en), .chan(chan), .pick_o(pick)
   );

   assign host_irq = glb && hen[0] && |(st & en);

   AST_STATUS_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ((st & $past(hit)) == $past(hit))); // R5
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
   localparam int N  = 64;
   localparam int NH = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [N-1:0] src;
   logic [12:0] b_addr;
   logic        b_wen;
   logic [31:0] b_wdata;
   logic [31:0] rdata;
   logic        irq;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   irqc_top #(.NUM_SRC(N), .NUM_HOST(NH), .ADDR_W(13), .SYNC_STAGES(2)) i_irqc_top (
      .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(b_addr), .bus_wen(b_wen),
      .bus_wdata(b_wdata), .bus_rdata(rdata), .host_irq(irq)
   );

   // behavioural reference model
   logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_en, m_pol, m_typ, h_hit;
   logic [7:0]   m_ch [N];
   logic         m_glb;
   logic [NH-1:0] m_hen;
   logic [31:0]  m_ctrl, m_hctrl, m_pri;

   function automatic logic [31:0] m_pick(input logic [N-1:0] p);
      int best = -1;
      int bc = 256;
      for (int i = 0; i < N; i++)
         if (p[i] && int'(m_ch[i]) < bc) begin best = i; bc = int'(m_ch[i]); end
      return (best < 0) ? 32'h8000_0000 : 32'(best);
   endfunction

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] v = '0;
      if (a == 'h04) v = m_ctrl;
      if (a == 'h0C) v = m_hctrl;
      if (a == 'h10) v = {31'b0, m_glb};
      if (a == 'h80) v = m_pri;
      if (a == 'h1500) v = {30'b0, m_hen};
      for (int w = 0; w < N/32; w++) begin
         if (a == 'h280 + 4*w) v = m_st[w*32 +: 32];
         if (a == 'h380 + 4*w) v = m_en[w*32 +: 32];
         if (a == 'hD00 + 4*w) v = m_pol[w*32 +: 32];
         if (a == 'hD80 + 4*w) v = m_typ[w*32 +: 32];
      end
      for (int m = 0; m < N/4; m++)
         if (a == 'h400 + 4*m) v = {m_ch[4*m+3], m_ch[4*m+2], m_ch[4*m+1], m_ch[4*m]};
      return v;
   endfunction

   task automatic m_write(input int a, input logic [31:0] d);
      int num = int'(d[9:0]);
      if (a == 'h24 && num < N)  m_st[num] = 1'b0;
      if (a == 'h28 && num < N)  m_en[num] = 1'b1;
      if (a == 'h2C && num < N)  m_en[num] = 1'b0;
      if (a == 'h34 && num < NH) m_hen[num] = 1'b1;
      if (a == 'h38 && num < NH) m_hen[num] = 1'b0;
      if (a == 'h1500) m_hen = d[NH-1:0];
      if (a == 'h10) m_glb = d[0];
      if (a == 'h04) m_ctrl = d;
      if (a == 'h0C) m_hctrl = d;
      for (int w = 0; w < N/32; w++) begin
         if (a == 'h280 + 4*w) m_st[w*32 +: 32] = m_st[w*32 +: 32] & ~d;
         if (a == 'h380 + 4*w) m_en[w*32 +: 32] = m_en[w*32 +: 32] & ~d;
         if (a == 'hD00 + 4*w) m_pol[w*32 +: 32] = d;
         if (a == 'hD80 + 4*w) m_typ[w*32 +: 32] = d;
      end
      for (int m = 0; m < N/4; m++)
         if (a == 'h400 + 4*m)
            for (int k = 0; k < 4; k++) m_ch[4*m+k] = d[8*k +: 8];
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_en = '0;
         m_pol = '0; m_typ = '0; m_glb = 1'b0; m_hen = '0;
         m_ctrl = '0; m_hctrl = '0; m_pri = 32'h8000_0000;
         for (int i = 0; i < N; i++) m_ch[i] = 8'd0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (m_typ[i])
               h_hit[i] = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
            else
               h_hit[i] = (m_s2[i] == m_pol[i]);
         end
         m_pri = m_pick(m_st & m_en);
         if (b_wen) m_write(int'(b_addr), b_wdata);
         m_st   = m_st | h_hit;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = src;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h (addr %h)", req, act, exp, b_addr);
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, rdata, m_read(int'(b_addr)));
         chk({cur_req, " R12 host_irq"}, {31'b0, irq},
             {31'b0, m_glb && m_hen[0] && |(m_st & m_en)});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual %0d cycles expected completion", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input int a, input bit w, input logic [31:0] d);
      @(posedge clk);
      #2;
      b_addr = 13'(a); b_wen = w; b_wdata = d;
   endtask
   task automatic wr(input int a, input logic [31:0] d); step(a, 1'b1, d); endtask
   task automatic rd(input int a); step(a, 1'b0, 32'h0); endtask
   task automatic idle(input int n); for (int i = 0; i < n; i++) rd('h80); endtask
   task automatic expect_rd(input string req, input logic [31:0] exp);
      @(negedge clk);
      chk(req, rdata, exp);
   endtask

   initial begin
      rst_n = 1'b0; src = '0; b_addr = 13'h80; b_wen = 1'b0; b_wdata = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      rd('h80);  expect_rd("R1 pri idx", 32'h8000_0000);
      chk("R1 host_irq", {31'b0, irq}, 32'h0);
      rd('h380); expect_rd("R1 enables", 32'h0);
      rd('h400); expect_rd("R1 channels", 32'h0);

      // R9: configuration words
      cur_req = "R9";
      wr('hD80, 32'hFFFF_FFFF);        // sources 0..31 edge
      wr('hD84, 32'h0000_0000);        // sources 32..63 level
      wr('hD00, 32'h0000_FFFF);        // 0..15 rising, 16..31 falling
      wr('hD04, 32'h7FFF_FFFF);        // 32..62 high, 63 low
      for (int m = 0; m < N/4; m++)
         wr('h400 + 4*m, {8'(4*m+3 + 7), 8'(4*m+2 + 7), 8'(4*m+1 + 7), 8'(4*m + 7)});
      wr('h400, 32'h0403_0205);
      wr('h40C, 32'h0809_0A02);        // source 12 channel 2
      wr('h428, 32'h0B0C_0D02);        // source 40 channel 2
      wr('h43C, 32'h0202_0202);        // sources 60..63 channel 2
      rd('h400); expect_rd("R9 map word 0", 32'h0403_0205);
      rd('hD04); expect_rd("R9 polarity word 1", 32'h7FFF_FFFF);

      // R8: clear all latched statuses
      cur_req = "R8";
      wr('h280, 32'hFFFF_FFFF);
      wr('h284, 32'hFFFF_FFFF);
      idle(3);
      rd('h280); expect_rd("R8 status word 0 cleared", 32'h0);

      // R2: synchronizer latency on source 5 (rising edge)
      cur_req = "R2";
      rd('h280); src[5] = 1'b1;
      @(negedge clk); chk("R2 before edge 1", {31'b0, rdata[5]}, 32'h0);
      rd('h280); @(negedge clk); chk("R2 after edge 1", {31'b0, rdata[5]}, 32'h0);
      rd('h280); @(negedge clk); chk("R2 after edge 2", {31'b0, rdata[5]}, 32'h0);
      rd('h280); @(negedge clk); chk("R2 after edge 3", {31'b0, rdata[5]}, 32'h1);

      // R7: host enables
      cur_req = "R7";
      wr('h34, 0); rd('h1500); expect_rd("R7 host 0 set", 32'h1);
      wr('h34, 1); wr('h34, 5); rd('h1500); expect_rd("R7 host 1 set", 32'h3);
      wr('h38, 1); rd('h1500); expect_rd("R7 host 1 cleared", 32'h1);
      wr('h1500, 32'h2); rd('h1500); expect_rd("R7 word write", 32'h2);
      wr('h1500, 32'h1);

      // R13: control words
      cur_req = "R13";
      wr('h04, 32'h0000_0012); wr('h0C, 32'h0000_0001);
      rd('h04); expect_rd("R13 ctrl readback", 32'h12);
      wr('h04, 0); wr('h0C, 0);

      // R6: index enables
      cur_req = "R6";
      wr('h28, 5); wr('h28, 12); wr('h28, 20); wr('h28, 40); wr('h28, 63);
      wr('h28, 100); wr('h2C, 12); wr('h2C, 700);
      rd('h380); expect_rd("R6 enable word 0", 32'h0010_0020);
      wr('h28, 12);

      // R12: global gate
      cur_req = "R12";
      rd('h80); idle(2);
      chk("R12 gated off", {31'b0, irq}, 32'h0);
      wr('h10, 1); idle(2);
      chk("R12 asserted", {31'b0, irq}, 32'h1);

      // R3: edges
      cur_req = "R3";
      src[3] = 1'b1; src[20] = 1'b1; idle(4);
      wr('h28, 3);
      src[3] = 1'b0; src[20] = 1'b0; idle(4);
      rd('h280); expect_rd("R3 rise 3 and fall 20", 32'h0010_0028);

      // R5: index clear colliding with a new edge, and plain clear
      cur_req = "R5";
      rd('h280); src[12] = 1'b1;
      rd('h280);
      wr('h24, 12);                    // lands with the edge event
      idle(2);
      rd('h280); expect_rd("R5 set wins", 32'h0010_1028);
      wr('h24, 3); wr('h24, 12); idle(2);
      rd('h280); expect_rd("R5 cleared", 32'h0010_0020);

      // R4: level sources
      cur_req = "R4";
      wr('h24, 63); idle(2);
      rd('h284); expect_rd("R4 level low persists", 32'h8000_0000);
      src[40] = 1'b1; idle(4);
      wr('h24, 40); idle(2);
      src[40] = 1'b0; idle(4);

      // R10: priority
      cur_req = "R10";
      src[12] = 1'b0; idle(3);
      src[12] = 1'b1; src[40] = 1'b1; idle(4);
      rd('h80); idle(2);
      wr('h2C, 12); idle(3);
      wr('h2C, 40); idle(3);
      wr('h2C, 63); idle(3);
      wr('h400, 32'h0403_0200); idle(3);

      // R11: nothing enabled
      cur_req = "R11";
      wr('h380, 32'hFFFF_FFFF); wr('h384, 32'hFFFF_FFFF); idle(2);
      rd('h80); expect_rd("R11 none flag", 32'h8000_0000);
      chk("R11 host_irq low", {31'b0, irq}, 32'h0);

      // R8: bulk clear words
      cur_req = "R8";
      wr('h28, 5); wr('h28, 33);
      wr('h280, 32'h0000_0020); wr('h380, 32'h0000_0020); idle(2);
      rd('h380); expect_rd("R8 enable word 0", 32'h0);
      rd('h384); expect_rd("R8 enable word 1", 32'h2);
      idle(4);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule